// File: doc/BRIEF.md
# Center-Aligned PWM Timer with Trigger Generation

This block is a 16-bit PWM time base that counts either in a sawtooth (edge-aligned) or in a triangle (center-aligned). In triangle mode the count climbs to the active period and shows that value for a second count. On that second count the direction turns down. The count then falls until it reaches zero, where it turns up again. The block marks the tops and the bottom with single-cycle pulses. It derives a once-per-cycle trigger from the upward top, and it drives a trigger line meant to start an analog-to-digital conversion.

Two shadowed registers sit beside the counter. The period shadow takes software writes while the timer runs and hands its value to the active period only at a cycle boundary. The output-pattern shadow feeds a multichannel pattern output. Its transfer is timed by a selectable event and may be delayed further by a synchronisation select. The conversion trigger can follow either the raw top pulses or the pattern transfer strobe. The raw top pulses give two triggers per triangle, and the pattern strobe gives one.

Top module: `capwm_timer`

## Requirements
- R1: After synchronous reset, count is 0, direction is up (1), every pulse output is 0 and the pattern output is 0.
- R2: With center_mode low and run high, the count steps 0,1,…,P and then wraps to 0 (P = active period), direction stays 1, period_match pulses in the cycle the count shows P, and zero_match pulses in the cycle the count shows 0 after a wrap.
- R3: With center_mode high and run high, counting from 0 gives 0,1,…,P,P,P-1,…,1,0,1,… (2P+1 counts per cycle). Direction is 1 from 0 through the first P and 0 from the second P through 1, changing on the same clock as the count turns.
- R4: In center mode, period_match pulses on both counts that show P, and zero_match pulses when the count reaches 0.
- R5: period_once pulses only on the period match reached while counting up, exactly once per timer cycle in either mode.
- R6: A period write while running only fills the shadow. shadow_xfer pulses together with the next period_once only if the shadow was written since the last transfer, and the active period takes the shadow value at the end of that cycle. The count completes its current cycle with the old period.
- R7: A period write while run is low loads the active period directly, so the next run uses it at once.
- R8: While run is low the count and direction hold and no pulse is produced.
- R9: A pattern write fills the pattern shadow. The 3-bit pattern transfer select picks the event that copies the shadow to pat_out, and pat_xfer pulses in the cycle the new value appears. Code 001 transfers on the cycle after a write, so the value appears two clocks after the write. Code 010 transfers on zero_match and code 101 transfers on period_once. Codes 000, 011, 100, 110 and 111 never transfer. An event-driven transfer appears one clock after its event.
- R10: The 2-bit pattern synchronisation select holds an event-driven transfer until a later qualifying event. Code 00 (and 11) applies the transfer directly. Code 01 waits for the next zero_match after the event, and code 10 waits for the next period_once after the event.
- R11: adc_trig equals period_match when adc_sel is 0 (two pulses per center-aligned top) and equals pat_xfer when adc_sel is 1 (one pulse per center-aligned cycle with select 101).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Count enable |
| center_mode | input | 1 | 1 = triangle counting, 0 = sawtooth counting |
| per_wr | input | 1 | Period write strobe |
| per_wdata | input | CNT_W | Period write value |
| pat_wr | input | 1 | Pattern shadow write strobe |
| pat_wdata | input | PAT_W | Pattern write value |
| pat_xfer_sel | input | 3 | Pattern transfer event select |
| pat_sync_sel | input | 2 | Pattern transfer synchronisation select |
| adc_sel | input | 1 | Conversion trigger source select |
| count | output | CNT_W | Timer count |
| count_up | output | 1 | Direction, 1 = counting up |
| period_match | output | 1 | Count shows the period value |
| zero_match | output | 1 | Count reached zero |
| period_once | output | 1 | Upward period match, once per cycle |
| shadow_xfer | output | 1 | Period shadow transfer strobe |
| pat_xfer | output | 1 | Pattern transfer strobe |
| pat_out | output | PAT_W | Active output pattern |
| adc_trig | output | 1 | Conversion trigger |

## Verification
The assertions take for granted that the active period is at least 1 and that center_mode changes only while the timer is stopped or in reset. They also assume that the pattern selects are not changed in the middle of a pending delayed transfer. The bench programs every period while run is low, right after a reset. It sets the mode and both selects before run rises, and it sweeps only periods from 1 upward. Period shadow writes while running happen only in sawtooth mode, and they land away from the transfer cycle.

// File: rtl/capwm_pkg.sv
package capwm_pkg;

  typedef struct packed {
    logic pm;     // count shows the period value
    logic once;   // upward period match
    logic zero;   // count reached zero
  } tmr_evt_t;

  localparam logic [2:0] XSEL_NONE   = 3'b000;
  localparam logic [2:0] XSEL_WRITE  = 3'b001;
  localparam logic [2:0] XSEL_ZERO   = 3'b010;
  localparam logic [2:0] XSEL_PERIOD = 3'b101;

  localparam logic [1:0] SYNC_DIRECT = 2'b00;
  localparam logic [1:0] SYNC_ZERO   = 2'b01;
  localparam logic [1:0] SYNC_PERIOD = 2'b10;

endpackage

// File: rtl/capwm_counter.sv
module capwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 center,
  input  logic [CNT_W-1:0]     per_act,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 up_q,
  output capwm_pkg::tmr_evt_t  evt_q,
  output logic                 once_nxt
);
  import capwm_pkg::*;

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_n;
  logic             up_n;
  tmr_evt_t         evt_n;

  always_comb begin
    cnt_n = cnt_q;
    up_n  = up_q;
    evt_n = '0;
    if (run) begin
      if (!center) begin
        up_n = 1'b1;
        if (cnt_q >= per_act) begin
          cnt_n      = '0;
          evt_n.zero = 1'b1;
        end else begin
          cnt_n = cnt_q + ONE;
        end
        evt_n.pm   = (cnt_n == per_act);
        evt_n.once = evt_n.pm;
      end else if (up_q) begin
        if (cnt_q >= per_act) begin
          // second count on the top value, turn down
          up_n     = 1'b0;
          evt_n.pm = 1'b1;
        end else begin
          cnt_n      = cnt_q + ONE;
          evt_n.pm   = (cnt_n == per_act);
          evt_n.once = evt_n.pm;
        end
      end else begin
        if (cnt_q <= ONE) begin
          cnt_n      = '0;
          up_n       = 1'b1;
          evt_n.zero = 1'b1;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
    end
  end

  assign once_nxt = evt_n.once;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      evt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
      evt_q <= evt_n;
    end
  end

  p_edge_dir_r2: assert property (@(posedge clk) disable iff (rst)
    (run && !center) |=> up_q) else $error("edge mode direction");

  p_top_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (run && center && up_q && cnt_q == per_act) |=> (cnt_q == $past(cnt_q) && !up_q))
    else $error("top value not held");

  p_bottom_turn_r3: assert property (@(posedge clk) disable iff (rst)
    (run && center && !up_q && cnt_q == ONE) |=> (cnt_q == '0 && up_q && evt_q.zero))
    else $error("bottom turn");

  p_pm_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (run && center && up_q && evt_q.pm) |=> (evt_q.pm && !evt_q.once))
    else $error("second period match missing");

  p_once_single_r5: assert property (@(posedge clk) disable iff (rst)
    evt_q.once |=> !evt_q.once) else $error("once pulse too long");

  p_once_in_pm_r5: assert property (@(posedge clk) disable iff (rst)
    evt_q.once |-> (evt_q.pm && up_q)) else $error("once without upward match");

  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == $past(cnt_q) && up_q == $past(up_q) && evt_q == '0))
    else $error("activity while stopped");

endmodule

// File: rtl/capwm_period.sv
module capwm_period #(
  parameter int          CNT_W      = 16,
  parameter int unsigned PERIOD_RST = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             once_nxt,
  output logic [CNT_W-1:0] per_act_q,
  output logic             xfer_q
);
  localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(PERIOD_RST);

  logic [CNT_W-1:0] shadow_q;
  logic             pending_q;
  logic             xfer_n;

  assign xfer_n = once_nxt && pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q  <= RST_VAL;
      per_act_q <= RST_VAL;
      pending_q <= 1'b0;
      xfer_q    <= 1'b0;
    end else begin
      xfer_q <= xfer_n;
      if (xfer_q) per_act_q <= shadow_q;
      if (per_wr) begin
        shadow_q <= per_wdata;
        if (!run) per_act_q <= per_wdata;
      end
      if (per_wr && run)      pending_q <= 1'b1;
      else if (per_wr)        pending_q <= 1'b0;
      else if (xfer_n)        pending_q <= 1'b0;
    end
  end

  p_xfer_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_q |=> !xfer_q) else $error("transfer strobe too long");

  p_act_loaded_r6: assert property (@(posedge clk) disable iff (rst)
    (xfer_q && !(per_wr && !run)) |=> per_act_q == $past(shadow_q))
    else $error("period not loaded");

  p_stopped_write_r7: assert property (@(posedge clk) disable iff (rst)
    (per_wr && !run) |=> per_act_q == $past(per_wdata))
    else $error("stopped write not direct");

endmodule

// File: rtl/capwm_pattern.sv
module capwm_pattern #(
  parameter int PAT_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pat_wr,
  input  logic [PAT_W-1:0]    pat_wdata,
  input  logic [2:0]          xsel,
  input  logic [1:0]          ssel,
  input  capwm_pkg::tmr_evt_t evt,
  output logic [PAT_W-1:0]    pat_q,
  output logic                xfer_q
);
  import capwm_pkg::*;

  logic [PAT_W-1:0] shadow_q;
  logic             wr_q;
  logic             armed_q;
  logic             ev, gate, fire, armed_n;

  always_comb begin
    case (xsel)
      XSEL_WRITE:  ev = wr_q;
      XSEL_ZERO:   ev = evt.zero;
      XSEL_PERIOD: ev = evt.once;
      default:     ev = 1'b0;
    endcase
    case (ssel)
      SYNC_ZERO:   gate = evt.zero;
      SYNC_PERIOD: gate = evt.once;
      default:     gate = 1'b1;
    endcase
    if (ssel == SYNC_ZERO || ssel == SYNC_PERIOD) begin
      fire    = armed_q && gate;
      armed_n = ev || (armed_q && !gate);
    end else begin
      fire    = ev;
      armed_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      pat_q    <= '0;
      wr_q     <= 1'b0;
      armed_q  <= 1'b0;
      xfer_q   <= 1'b0;
    end else begin
      if (pat_wr) shadow_q <= pat_wdata;
      wr_q    <= pat_wr;
      armed_q <= armed_n;
      xfer_q  <= fire;
      if (fire) pat_q <= shadow_q;
    end
  end

  p_xfer_loads_r9: assert property (@(posedge clk) disable iff (rst)
    xfer_q |-> pat_q == $past(shadow_q)) else $error("pattern copy wrong");

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !xfer_q |-> pat_q == $past(pat_q)) else $error("pattern changed without strobe");

  p_direct_r10: assert property (@(posedge clk) disable iff (rst)
    (ssel == SYNC_DIRECT && xsel == XSEL_PERIOD && evt.once) |=> xfer_q)
    else $error("direct transfer missing");

endmodule

// File: rtl/capwm_timer.sv
module capwm_timer #(
  parameter int          CNT_W      = 16,
  parameter int          PAT_W      = 6,
  parameter int unsigned PERIOD_RST = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             center_mode,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             pat_wr,
  input  logic [PAT_W-1:0] pat_wdata,
  input  logic [2:0]       pat_xfer_sel,
  input  logic [1:0]       pat_sync_sel,
  input  logic             adc_sel,
  output logic [CNT_W-1:0] count,
  output logic             count_up,
  output logic             period_match,
  output logic             zero_match,
  output logic             period_once,
  output logic             shadow_xfer,
  output logic             pat_xfer,
  output logic [PAT_W-1:0] pat_out,
  output logic             adc_trig
);
  import capwm_pkg::*;

  logic [CNT_W-1:0] per_act;
  tmr_evt_t         evt;
  logic             once_nxt;

  capwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .center(center_mode),
    .per_act(per_act), .cnt_q(count), .up_q(count_up),
    .evt_q(evt), .once_nxt(once_nxt)
  );

  capwm_period #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) u_per (
    .clk(clk), .rst(rst), .run(run), .per_wr(per_wr),
    .per_wdata(per_wdata), .once_nxt(once_nxt),
    .per_act_q(per_act), .xfer_q(shadow_xfer)
  );

  capwm_pattern #(.PAT_W(PAT_W)) u_pat (
    .clk(clk), .rst(rst), .pat_wr(pat_wr), .pat_wdata(pat_wdata),
    .xsel(pat_xfer_sel), .ssel(pat_sync_sel), .evt(evt),
    .pat_q(pat_out), .xfer_q(pat_xfer)
  );

  assign period_match = evt.pm;
  assign zero_match   = evt.zero;
  assign period_once  = evt.once;
  assign adc_trig     = adc_sel ? pat_xfer : evt.pm;

  p_xfer_with_once_r6: assert property (@(posedge clk) disable iff (rst)
    shadow_xfer |-> period_once) else $error("shadow transfer off the upward match");

  p_adc_src_r11: assert property (@(posedge clk) disable iff (rst)
    (!adc_sel && center_mode && period_match && count_up) |=> adc_trig)
    else $error("second conversion trigger missing");

endmodule

// File: tb/test_capwm_timer.sv
module test_capwm_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic        center_mode = 1'b0;
  logic        per_wr = 1'b0;
  logic [15:0] per_wdata = '0;
  logic        pat_wr = 1'b0;
  logic [5:0]  pat_wdata = '0;
  logic [2:0]  pat_xfer_sel = '0;
  logic [1:0]  pat_sync_sel = '0;
  logic        adc_sel = 1'b0;
  logic [15:0] count;
  logic        count_up, period_match, zero_match, period_once;
  logic        shadow_xfer, pat_xfer, adc_trig;
  logic [5:0]  pat_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  capwm_timer i_capwm_timer (
    .clk(clk), .rst(rst), .run(run), .center_mode(center_mode),
    .per_wr(per_wr), .per_wdata(per_wdata), .pat_wr(pat_wr),
    .pat_wdata(pat_wdata), .pat_xfer_sel(pat_xfer_sel),
    .pat_sync_sel(pat_sync_sel), .adc_sel(adc_sel), .count(count),
    .count_up(count_up), .period_match(period_match),
    .zero_match(zero_match), .period_once(period_once),
    .shadow_xfer(shadow_xfer), .pat_xfer(pat_xfer), .pat_out(pat_out),
    .adc_trig(adc_trig)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load_period(input int p);
    per_wr = 1'b1; per_wdata = 16'(p);
    @(negedge clk);
    per_wr = 1'b0;
  endtask

  // R2 R3 R4 R5 R7 R11: arithmetic sweep of one configuration
  task automatic sweep(input logic cm, input int p);
    int len;
    do_reset();
    center_mode = cm; adc_sel = 1'b0;
    load_period(p);
    run = 1'b1;
    len = cm ? 2 * p + 1 : p + 1;
    for (int n = 1; n <= 3 * len; n++) begin
      int i, ec, eu, epm;
      @(negedge clk);
      i = n % len;
      if (!cm) begin
        ec = i; eu = 1; epm = (i == p) ? 1 : 0;
      end else begin
        ec  = (i <= p) ? i : 2 * p + 1 - i;
        eu  = (i <= p) ? 1 : 0;
        epm = (i == p || i == p + 1) ? 1 : 0;
      end
      chk(cm ? "R3 count" : "R2 count", int'(count), ec);
      chk(cm ? "R3 dir" : "R2 dir", int'(count_up), eu);
      chk(cm ? "R4 pmatch" : "R2 pmatch", int'(period_match), epm);
      chk(cm ? "R4 zero" : "R2 zero", int'(zero_match), (i == 0) ? 1 : 0);
      chk("R5 once", int'(period_once), (i == p) ? 1 : 0);
      chk("R6 no strobe without write", int'(shadow_xfer), 0);
      chk("R11 adc raw", int'(adc_trig), epm);
    end
    run = 1'b0;
  endtask

  // R9 R10 R11: pattern transfer timing in center mode, period 3
  task automatic pat_case(input logic [2:0] xs, input logic [1:0] ss,
                          input int idx, input int minn, input string tag);
    do_reset();
    center_mode = 1'b1; adc_sel = 1'b1;
    pat_xfer_sel = xs; pat_sync_sel = ss;
    load_period(3);
    pat_wr = 1'b1; pat_wdata = 6'h2A;
    @(negedge clk);
    pat_wr = 1'b0;
    run = 1'b1;
    for (int n = 1; n <= 21; n++) begin
      int ex, ep;
      @(negedge clk);
      ex = (idx >= 0 && n >= minn && (n % 7) == idx) ? 1 : 0;
      ep = (idx >= 0 && n >= minn) ? 'h2A : 0;
      chk({tag, " strobe"}, int'(pat_xfer), ex);
      chk({"R11 adc ", tag}, int'(adc_trig), ex);
      chk({tag, " pattern"}, int'(pat_out), ep);
    end
    run = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1: reset state
    @(negedge clk);
    chk("R1 count", int'(count), 0);
    chk("R1 dir", int'(count_up), 1);
    chk("R1 pmatch", int'(period_match), 0);
    chk("R1 zero", int'(zero_match), 0);
    chk("R1 once", int'(period_once), 0);
    chk("R1 shadow strobe", int'(shadow_xfer), 0);
    chk("R1 pattern", int'(pat_out), 0);

    for (int p = 1; p <= 6; p++) begin
      sweep(1'b0, p);
      sweep(1'b1, p);
    end

    // R6: running write in edge mode, period 3 -> 5
    do_reset();
    center_mode = 1'b0; adc_sel = 1'b0;
    load_period(3);
    run = 1'b1;
    for (int n = 1; n <= 11; n++) begin
      @(negedge clk);
      per_wr = (n == 1);
      per_wdata = 16'd5;
      if (n == 3) begin
        chk("R6 count at strobe", int'(count), 3);
        chk("R6 strobe", int'(shadow_xfer), 1);
      end
      if (n == 4) begin
        chk("R6 old period kept", int'(count), 0);
        chk("R6 strobe single", int'(shadow_xfer), 0);
      end
      if (n == 8) chk("R6 new period counts past old", int'(count), 4);
      if (n == 9) begin
        chk("R6 new top", int'(count), 5);
        chk("R6 new top match", int'(period_match), 1);
        chk("R6 no repeat strobe", int'(shadow_xfer), 0);
      end
      if (n == 10) chk("R6 wrap", int'(count), 0);
    end
    run = 1'b0;

    // R8: stop holds state
    do_reset();
    center_mode = 1'b0;
    load_period(5);
    run = 1'b1;
    repeat (3) @(negedge clk);
    run = 1'b0;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R8 count held", int'(count), 3);
      chk("R8 dir held", int'(count_up), 1);
      chk("R8 no pulse", int'(period_match | zero_match | period_once), 0);
    end

    // R9 R10 transfer event and synchronisation selects
    pat_case(3'b101, 2'b00, 4, 4,  "R9 sel101");
    pat_case(3'b010, 2'b00, 1, 8,  "R9 sel010");
    pat_case(3'b000, 2'b00, -1, 0, "R9 sel000");
    pat_case(3'b011, 2'b00, -1, 0, "R9 sel011");
    pat_case(3'b101, 2'b01, 1, 8,  "R10 sync01");
    pat_case(3'b010, 2'b10, 4, 11, "R10 sync10");
    pat_case(3'b101, 2'b11, 4, 4,  "R10 sync11");

    // R9: transfer on write, select 001
    do_reset();
    pat_xfer_sel = 3'b001; pat_sync_sel = 2'b00;
    pat_wr = 1'b1; pat_wdata = 6'h15;
    @(negedge clk);
    pat_wr = 1'b0;
    chk("R9 write not yet applied", int'(pat_out), 0);
    chk("R9 write strobe early", int'(pat_xfer), 0);
    @(negedge clk);
    chk("R9 write applied", int'(pat_out), 'h15);
    chk("R9 write strobe", int'(pat_xfer), 1);
    @(negedge clk);
    chk("R9 write strobe single", int'(pat_xfer), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule